// File: doc/BRIEF.md
# Phase Accumulator with Switchable Register Select

This block is the phase engine of a direct digital synthesizer. It stores two frequency tuning words and two phase offset words, all loaded through a single synchronous write port. On every rising clock edge it adds the active tuning word into a wrapping phase accumulator. It then adds the active phase offset to the accumulator's most significant bits and registers the sum as a phase value for a waveform lookup further down the chain.

The active tuning word and the active phase offset are each chosen by a one-bit select. A mode bit in the control register decides where both selects come from. With the mode bit set, two external select pins drive them. With the mode bit clear, two select bits in the control register drive them. The pins are captured on the falling clock edge, so a pin value changed between edges is used at the next rising edge, with a fixed latency.

The output frequency is f_clk * word / 2^ACC_W. One output LSB is a phase step of 2*pi / 2^PH_W.

Top module: `nco_phase_gen`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, every stored word, the control register and `phase_out` to zero. After reset the output stays at zero until a tuning word is loaded.
- R2: When `wr_en` is high at a rising edge, the write loads one register and the new value is used from the next rising edge on. Address 0 loads frequency word 0 and address 1 loads frequency word 1, each from `wr_data[27:0]`. Address 2 loads phase word 0 and address 3 loads phase word 1, each from `wr_data[11:0]`.
- R3: On every rising edge after reset, the 28-bit accumulator adds the selected frequency word, wrapping modulo 2^28.
- R4: At each rising edge, `phase_out` is registered as accumulator bits [27:16] plus the selected phase word, taken modulo 4096. Both values are the ones held before that edge.
- R5: Address 4 loads the control register. Bit 0 is the frequency select, bit 1 is the phase select and bit 2 is the pin mode. A select of 0 picks word 0 and a select of 1 picks word 1.
- R6: With the pin mode at 0, the control bits choose the active words and the pins `fsel_pin` and `psel_pin` have no effect on `phase_out`.
- R7: With the pin mode at 1, the pins choose the active words and the control select bits have no effect. A pin value is captured at a falling edge and used at the rising edge that follows it.
- R8: Writes to addresses 5, 6 and 7 change no stored value and leave `phase_out` unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register address (0-1 frequency, 2-3 phase, 4 control) |
| wr_data | input | 28 | Write data |
| fsel_pin | input | 1 | External frequency select, captured on falling edge |
| psel_pin | input | 1 | External phase select, captured on falling edge |
| phase_out | output | 12 | Registered phase value for waveform lookup |

## Verification
A wrong accumulator value or a wrong tuning-word choice changes the slope of `phase_out` across cycles. A step error of one unit in the top bits shows up within one cycle, while a fault confined to the low accumulator bits reaches the output only as a carry, after up to 2^16 cycles at small tuning words. A wrong phase word or phase select shifts `phase_out` by a constant in the very next cycle. For this reason the offsets differ strongly from each other, and the sweeps cover every select combination in both modes with the unused select source driven opposite to the active one. Tuning words are chosen so that carries into the top bits happen every few cycles, so the low bits are exercised too.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] FREQ_BASE = 3'd0;
  localparam logic [ADDR_W-1:0] PHS_BASE  = 3'd2;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 3'd4;

  typedef struct packed {
    logic pin_mode;
    logic psel;
    logic fsel;
  } ctrl_t;
endpackage

// File: rtl/nco_regfile.sv
module nco_regfile
  import nco_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12,
  parameter int NSET  = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [ACC_W-1:0]            wr_data,
  output logic [NSET-1:0][ACC_W-1:0]  freq_words,
  output logic [NSET-1:0][PH_W-1:0]   phase_words,
  output ctrl_t                       ctrl_q
);

  for (genvar g = 0; g < NSET; g++) begin : g_set
    localparam logic [ADDR_W-1:0] FA = FREQ_BASE + ADDR_W'(g);
    localparam logic [ADDR_W-1:0] PA = PHS_BASE + ADDR_W'(g);

    always_ff @(posedge clk) begin
      if (rst) begin
        freq_words[g]  <= '0;
        phase_words[g] <= '0;
      end else if (wr_en) begin
        if (wr_addr == FA) freq_words[g]  <= wr_data;
        if (wr_addr == PA) phase_words[g] <= wr_data[PH_W-1:0];
      end
    end

    // R2
    freq_load_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == FA) |=> freq_words[g] == $past(wr_data));
    // R2
    phase_load_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == PA) |=> phase_words[g] == $past(wr_data[PH_W-1:0]));
  end

  always_ff @(posedge clk) begin
    if (rst)                             ctrl_q <= '0;
    else if (wr_en && wr_addr == CTRL_ADDR) ctrl_q <= ctrl_t'(wr_data[2:0]);
  end

  // R8
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > CTRL_ADDR) |=>
      ($stable(freq_words) && $stable(phase_words) && $stable(ctrl_q)));

endmodule

// File: rtl/nco_pin_capture.sv
module nco_pin_capture #(
  parameter int NPIN = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pins_in,
  output logic [NPIN-1:0] pins_q
);

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    always_ff @(negedge clk) begin
      if (rst) pins_q[g] <= 1'b0;
      else     pins_q[g] <= pins_in[g];
    end
  end

endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ACC_W-1:0] step_word,
  input  logic [PH_W-1:0]  offset_word,
  output logic [PH_W-1:0]  phase_out
);

  localparam int TOP_LO = ACC_W - PH_W;

  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      phase_out <= '0;
    end else begin
      acc_q     <= acc_q + step_word;
      phase_out <= acc_q[ACC_W-1:TOP_LO] + offset_word;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && phase_out == '0));
  // R3
  acc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> acc_q == ACC_W'($past(acc_q) + $past(step_word)));
  // R4
  phase_sum_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> phase_out ==
      PH_W'($past(acc_q[ACC_W-1:TOP_LO]) + $past(offset_word)));

endmodule

// File: rtl/nco_phase_gen.sv
module nco_phase_gen
  import nco_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [ACC_W-1:0]    wr_data,
  input  logic                fsel_pin,
  input  logic                psel_pin,
  output logic [PH_W-1:0]     phase_out
);

  localparam int NSET = 2;

  logic [NSET-1:0][ACC_W-1:0] freq_words;
  logic [NSET-1:0][PH_W-1:0]  phase_words;
  ctrl_t                      ctrl_q;
  logic [1:0]                 pins_q;
  logic                       fsel_eff;
  logic                       psel_eff;

  nco_regfile #(.ACC_W(ACC_W), .PH_W(PH_W), .NSET(NSET)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .freq_words (freq_words),
    .phase_words(phase_words),
    .ctrl_q     (ctrl_q)
  );

  nco_pin_capture #(.NPIN(2)) u_pins (
    .clk    (clk),
    .rst    (rst),
    .pins_in({psel_pin, fsel_pin}),
    .pins_q (pins_q)
  );

  always_comb begin
    fsel_eff = ctrl_q.pin_mode ? pins_q[0] : ctrl_q.fsel;
    psel_eff = ctrl_q.pin_mode ? pins_q[1] : ctrl_q.psel;
  end

  nco_accum #(.ACC_W(ACC_W), .PH_W(PH_W)) u_accum (
    .clk        (clk),
    .rst        (rst),
    .step_word  (freq_words[fsel_eff]),
    .offset_word(phase_words[psel_eff]),
    .phase_out  (phase_out)
  );

  // R5
  ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == CTRL_ADDR) |=> ctrl_q == ctrl_t'($past(wr_data[2:0])));

endmodule

// File: tb/test_nco_phase_gen.sv
module test_nco_phase_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [27:0] wr_data = '0;
  logic        fsel_pin = 1'b0;
  logic        psel_pin = 1'b0;
  logic [11:0] phase_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [27:0] m_acc;
  logic [27:0] m_fr [2];
  logic [11:0] m_ph [2];
  bit m_fsel, m_psel, m_mode;
  logic [11:0] exp_out;

  always #2 clk = ~clk;

  nco_phase_gen i_nco_phase_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fsel_pin(fsel_pin), .psel_pin(psel_pin), .phase_out(phase_out)
  );

  task automatic check(input logic [11:0] act, input logic [11:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s phase_out actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_acc = '0; m_fr[0] = '0; m_fr[1] = '0; m_ph[0] = '0; m_ph[1] = '0;
    m_fsel = 0; m_psel = 0; m_mode = 0; exp_out = '0;
  endtask

  // Called at posedge+1; applies inputs, waits one rising edge, checks.
  task automatic step(input bit we, input logic [2:0] a, input logic [27:0] d,
                      input bit fp, input bit pp, input string tag);
    bit fs, ps;
    wr_en = we; wr_addr = a; wr_data = d; fsel_pin = fp; psel_pin = pp;
    @(posedge clk);
    fs = m_mode ? fp : m_fsel;
    ps = m_mode ? pp : m_psel;
    exp_out = m_acc[27:16] + m_ph[ps];
    m_acc = m_acc + m_fr[fs];
    if (we) begin
      if (a < 3'd2)       m_fr[a[0]] = d;
      else if (a < 3'd4)  m_ph[a[0]] = d[11:0];
      else if (a == 3'd4) begin m_fsel = d[0]; m_psel = d[1]; m_mode = d[2]; end
    end
    #1;
    check(phase_out, exp_out, tag);
  endtask

  task automatic idle(input int n, input bit fp, input bit pp, input string tag);
    for (int i = 0; i < n; i++) step(0, 3'd0, '0, fp, pp, tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    check(phase_out, 12'h000, "R1");
    idle(4, 1, 1, "R1");

    // R2 / R3: one top-bit unit per cycle, then a fractional step
    step(1, 3'd0, 28'h0010000, 0, 0, "R2");
    idle(20, 0, 0, "R3");
    step(1, 3'd0, 28'h0005555, 0, 0, "R2");
    idle(30, 0, 0, "R3");
    // R4: phase offsets
    step(1, 3'd2, 28'h0000800, 0, 0, "R2");
    idle(10, 0, 0, "R4");
    step(1, 3'd3, 28'hABC0123, 0, 0, "R2");
    step(1, 3'd1, 28'hFFF0000, 0, 0, "R2");
    idle(6, 0, 0, "R4");

    // R5 / R6 / R7: all select combinations in both modes
    for (int mode = 0; mode < 2; mode++) begin
      for (int c = 0; c < 4; c++) begin
        logic [27:0] cw;
        bit fp, pp;
        if (mode == 0) begin
          cw = {25'd0, 1'b0, c[1], c[0]};
          fp = ~c[0]; pp = ~c[1];
        end else begin
          cw = {25'd0, 1'b1, ~c[1], ~c[0]};
          fp = c[0]; pp = c[1];
        end
        step(1, 3'd4, cw, fp, pp, "R5");
        for (int i = 0; i < 12; i++)
          step(0, 3'd0, '0, fp, pp, (mode == 0) ? "R6" : "R7");
      end
    end

    // R7: pins toggling every cycle, fixed one-edge latency
    for (int i = 0; i < 24; i++) step(0, 3'd0, '0, i[0], i[1], "R7");

    // R3 / R4: accumulator and phase-sum wrap
    step(1, 3'd4, 28'h0, 0, 0, "R5");
    step(1, 3'd0, 28'hFFFFFFF, 0, 0, "R2");
    step(1, 3'd2, 28'h0000FFF, 0, 0, "R2");
    idle(20, 0, 0, "R3");
    step(1, 3'd0, 28'h7FF0000, 0, 0, "R2");
    idle(20, 0, 0, "R4");

    // R8: unmapped addresses
    for (int a = 5; a < 8; a++) begin
      step(1, 3'(a), 28'hFFFFFFF, 0, 0, "R8");
      idle(6, 0, 0, "R8");
    end

    // R1: reset in mid-run
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    model_reset();
    check(phase_out, 12'h000, "R1");
    idle(8, 1, 0, "R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule